// File: doc/BRIEF.md
# Phase Alignment Test Sequencer

This block runs a burst of timed phase-test rounds and grades the result. A single-cycle `go_i` in idle starts a run of `ROUNDS` rounds. Each round lines up with a rising edge of `sync_i`. It then opens the phase switch by pulling `clamp_n_o` low for a fixed time, lets the hardware settle, and watches `aligned_i` for a bounded number of cycles. A round in which the input goes high is graded "much". A round that sees no high sample is graded "little". The grade steps an adjustable phase offset down or up, and it chooses the 2-bit code that `ctrl_code_o` carries for a short burst on the next sync edge. Outside the burst, `ctrl_code_o` follows `rest_code_i`.

When all rounds are done, the block checks whether every round agreed. All "much" gives an under-advanced fault. All "little" gives an over-advanced fault. A mixed run is a pass. A pass is reported only when `jet_active_i` is low. A fault is raised only once: while `phase_fault_o` is latched, later faults are suppressed. All delays are whole timing units of `UNIT_CYC` clock cycles.

States: `ST_IDLE`, `ST_REQ_CHK`, `ST_SYNC_LO`, `ST_SYNC_HI`, `ST_CLAMP`, `ST_SETTLE`, `ST_POLL`, `ST_CLASSIFY`, `ST_REQ_CHK2`, `ST_SYNC2_LO`, `ST_SYNC2_HI`, `ST_BURST`, `ST_GAP`, `ST_EVAL`.

Transitions:
- `ST_IDLE` goes to `ST_REQ_CHK` on `go_i`.
- `ST_REQ_CHK` goes to `ST_SYNC_LO` if `phase_req_i` is high, and otherwise to `ST_IDLE`.
- `ST_SYNC_LO` goes to `ST_SYNC_HI` once sync is low.
- `ST_SYNC_HI` goes to `ST_CLAMP` once sync is high.
- `ST_CLAMP` goes to `ST_SETTLE` when its timer ends.
- `ST_SETTLE` goes to `ST_POLL` when its timer ends.
- `ST_POLL` goes to `ST_CLASSIFY` on the first high sample or on the last sample.
- `ST_CLASSIFY` goes to `ST_REQ_CHK2`.
- `ST_REQ_CHK2` goes to `ST_SYNC2_LO` if the request is still high, and otherwise to `ST_IDLE`.
- `ST_SYNC2_LO` goes to `ST_SYNC2_HI` once sync is low.
- `ST_SYNC2_HI` goes to `ST_BURST` once sync is high.
- `ST_BURST` goes to `ST_GAP` when its timer ends.
- `ST_GAP` goes to `ST_REQ_CHK` when its timer ends, or to `ST_EVAL` after the last round.
- `ST_EVAL` goes to `ST_IDLE`.

Top module: `phase_align_seq`

## Requirements
- R1: After reset the outputs are as follows: `clamp_n_o`=1, `busy_o`=0, `ready_o`=0, `phase_fault_o`=0, `warn_o`=0, `hv_on_o`=0, no pulse outputs, `ctrl_code_o`=`rest_code_i`, and `offset_o`=2^(OFFSET_W-1).
- R2: `go_i` in idle starts a run. If `phase_req_i` is low when a round begins, the run aborts to idle with no outcome pulse.
- R3: Each round's clamp pulse begins on the first clock edge at which `sync_i` is seen high after it was seen low.
- R4: `clamp_n_o` is low for exactly `CLAMP_UNITS`×`UNIT_CYC` cycles per round (57 units by default). A `SETTLE_UNITS` settle follows (30 units).
- R5: `busy_o` rises together with the first clamp pulse. It stays high until the run ends or aborts.
- R6: After the settle, `aligned_i` is sampled once per cycle for up to `POLL_LIMIT` cycles (default 50). The first high sample grades the round "much". No high sample grades it "little".
- R7: A "much" round decrements `offset_o` unless the result would be 0. A "little" round increments it unless the result would wrap to 0.
- R8: After grading, `phase_req_i` is checked again. If it is low, the run aborts before the code burst.
- R9: On the next `sync_i` rising edge, `ctrl_code_o` carries 2'b10 (much) or 2'b00 (little) for `BURST_UNITS`×`UNIT_CYC` cycles. It then returns to `rest_code_i`, and a `GAP_UNITS` gap follows.
- R10: At the end of a run, a much count of at least `ROUNDS` raises the under-advanced fault (`fault_under_o` pulse). Otherwise a little count of at least `ROUNDS` raises the over-advanced fault (`fault_over_o` pulse). Both counts restart at zero for every run.
- R11: Raising a fault sets `phase_fault_o` and `warn_o` and clears `hv_on_o`. No fault is raised, and nothing changes, while `phase_fault_o` is already set.
- R12: When no fault condition applies and `jet_active_i` is low, the run ends with a one-cycle `pass_o` pulse that sets `ready_o`. If `jet_active_i` is high, no pass pulse is given.
- R13: Accepting `go_i` sets `hv_on_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Run start strobe |
| phase_req_i | input | 1 | Phase request; low aborts at the checkpoints |
| sync_i | input | 1 | Sync reference; rounds align to its rising edge |
| aligned_i | input | 1 | Alignment indicator that is polled |
| jet_active_i | input | 1 | High suppresses the pass report |
| rest_code_i | input | 2 | Code that `ctrl_code_o` carries outside the burst |
| clamp_n_o | output | 1 | Phase switch clamp, active low |
| ctrl_code_o | output | 2 | Control code (burst or rest value) |
| busy_o | output | 1 | Run in progress, from first clamp pulse |
| pass_o | output | 1 | One-cycle pass pulse |
| fault_under_o | output | 1 | One-cycle under-advanced fault pulse |
| fault_over_o | output | 1 | One-cycle over-advanced fault pulse |
| phase_fault_o | output | 1 | Latched phase fault flag |
| warn_o | output | 1 | Warning lamp |
| hv_on_o | output | 1 | High-voltage-on status |
| ready_o | output | 1 | Ready / green relay |
| offset_o | output | OFFSET_W | Adjustable phase offset |

## Verification
The hardest state to reach is the abort at the second request check. The request has to fall after a round has been graded but before that round's code burst. A drop at any other time looks the same from the ports, because the abort at the next round start also ends the run. The stimulus counts clamp edges and drops `phase_req_i` partway through the first settle interval, with `aligned_i` held high. The graded offset step then appears on `offset_o`, but no 2'b10 burst ever shows on `ctrl_code_o`. The offset ceiling and floor are reached in a single run by building the bench with a 4-bit offset.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ_CHK,
        ST_SYNC_LO,
        ST_SYNC_HI,
        ST_CLAMP,
        ST_SETTLE,
        ST_POLL,
        ST_CLASSIFY,
        ST_REQ_CHK2,
        ST_SYNC2_LO,
        ST_SYNC2_HI,
        ST_BURST,
        ST_GAP,
        ST_EVAL
    } seq_state_t;

    localparam int UNITS_W = 8;

endpackage

// File: rtl/phase_unit_timer.sv
module phase_unit_timer #(
    parameter int UNIT_CYC = 4,
    parameter int UNITS_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [UNITS_W-1:0] units_i,
    output logic               done_o
);
    localparam int MAX_CYC = ((1 << UNITS_W) - 1) * UNIT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Down-counter: a load of N units keeps done_o low for N*UNIT_CYC-1 cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(int'(units_i) * UNIT_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

    // R4
    tmr_idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (cnt_q == '0));

endmodule

// File: rtl/phase_tally.sv
module phase_tally #(
    parameter int ROUNDS   = 16,
    parameter int OFFSET_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr_i,
    input  logic                             upd_i,
    input  logic                             much_i,
    output logic [$clog2(ROUNDS+1)-1:0]      much_cnt_o,
    output logic [$clog2(ROUNDS+1)-1:0]      little_cnt_o,
    output logic [OFFSET_W-1:0]              offset_o
);
    localparam int CW = $clog2(ROUNDS + 1);
    localparam logic [OFFSET_W-1:0] OFF_INIT = OFFSET_W'(1) << (OFFSET_W - 1);
    localparam logic [OFFSET_W-1:0] OFF_MAX  = '1;

    logic [CW-1:0]       much_q, little_q;
    logic [OFFSET_W-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            much_q   <= '0;
            little_q <= '0;
        end else if (clr_i) begin
            much_q   <= '0;
            little_q <= '0;
        end else if (upd_i) begin
            if (much_i && much_q != CW'(ROUNDS)) begin
                much_q <= much_q + 1'b1;
            end else if (!much_i && little_q != CW'(ROUNDS)) begin
                little_q <= little_q + 1'b1;
            end
        end
    end

    // Saturating offset: never steps onto zero from either side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= OFF_INIT;
        end else if (upd_i) begin
            if (much_i && off_q > OFFSET_W'(1)) begin
                off_q <= off_q - 1'b1;
            end else if (!much_i && off_q != OFF_MAX) begin
                off_q <= off_q + 1'b1;
            end
        end
    end

    assign much_cnt_o   = much_q;
    assign little_cnt_o = little_q;
    assign offset_o     = off_q;

    // R7
    offset_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_q != '0);

    // R7
    offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_q != $past(off_q)) |->
            ((off_q - $past(off_q) == OFFSET_W'(1)) || ($past(off_q) - off_q == OFFSET_W'(1))));

endmodule

// File: rtl/phase_align_seq.sv
module phase_align_seq
    import phase_seq_pkg::*;
#(
    parameter int ROUNDS       = 16,
    parameter int UNIT_CYC     = 4,
    parameter int CLAMP_UNITS  = 57,
    parameter int SETTLE_UNITS = 30,
    parameter int POLL_LIMIT   = 50,
    parameter int BURST_UNITS  = 2,
    parameter int GAP_UNITS    = 37,
    parameter int OFFSET_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_i,
    input  logic                phase_req_i,
    input  logic                sync_i,
    input  logic                aligned_i,
    input  logic                jet_active_i,
    input  logic [1:0]          rest_code_i,
    output logic                clamp_n_o,
    output logic [1:0]          ctrl_code_o,
    output logic                busy_o,
    output logic                pass_o,
    output logic                fault_under_o,
    output logic                fault_over_o,
    output logic                phase_fault_o,
    output logic                warn_o,
    output logic                hv_on_o,
    output logic                ready_o,
    output logic [OFFSET_W-1:0] offset_o
);
    localparam int CW = $clog2(ROUNDS + 1);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    seq_state_t state_q, nxt;

    logic               tmr_load, tmr_done;
    logic [UNITS_W-1:0] tmr_units;
    logic               tally_clr, tally_upd;
    logic [CW-1:0]      much_cnt, little_cnt, rounds_q;
    logic [PW-1:0]      poll_q;
    logic               much_q, poll_last;
    logic               busy_q, pass_q, under_q, over_q;
    logic               flag_q, warn_q, hv_q, ready_q;
    logic               under_cond, over_cond;

    assign poll_last  = (poll_q == PW'(POLL_LIMIT - 1));
    assign under_cond = (much_cnt >= CW'(ROUNDS));
    assign over_cond  = !under_cond && (little_cnt >= CW'(ROUNDS));

    phase_unit_timer #(.UNIT_CYC(UNIT_CYC), .UNITS_W(UNITS_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .units_i (tmr_units),
        .done_o  (tmr_done)
    );

    phase_tally #(.ROUNDS(ROUNDS), .OFFSET_W(OFFSET_W)) u_tally (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (tally_clr),
        .upd_i        (tally_upd),
        .much_i       (much_q),
        .much_cnt_o   (much_cnt),
        .little_cnt_o (little_cnt),
        .offset_o     (offset_o)
    );

    // Next-state and timer-load decode
    always_comb begin
        nxt       = state_q;
        tmr_load  = 1'b0;
        tmr_units = '0;
        tally_clr = 1'b0;
        tally_upd = 1'b0;
        unique case (state_q)
            ST_IDLE: if (go_i) begin
                nxt       = ST_REQ_CHK;
                tally_clr = 1'b1;
            end
            ST_REQ_CHK:  nxt = phase_req_i ? ST_SYNC_LO : ST_IDLE;
            ST_SYNC_LO:  if (!sync_i) nxt = ST_SYNC_HI;
            ST_SYNC_HI: if (sync_i) begin
                nxt       = ST_CLAMP;
                tmr_load  = 1'b1;
                tmr_units = UNITS_W'(CLAMP_UNITS);
            end
            ST_CLAMP: if (tmr_done) begin
                nxt       = ST_SETTLE;
                tmr_load  = 1'b1;
                tmr_units = UNITS_W'(SETTLE_UNITS);
            end
            ST_SETTLE:   if (tmr_done) nxt = ST_POLL;
            ST_POLL:     if (aligned_i || poll_last) nxt = ST_CLASSIFY;
            ST_CLASSIFY: begin
                nxt       = ST_REQ_CHK2;
                tally_upd = 1'b1;
            end
            ST_REQ_CHK2: nxt = phase_req_i ? ST_SYNC2_LO : ST_IDLE;
            ST_SYNC2_LO: if (!sync_i) nxt = ST_SYNC2_HI;
            ST_SYNC2_HI: if (sync_i) begin
                nxt       = ST_BURST;
                tmr_load  = 1'b1;
                tmr_units = UNITS_W'(BURST_UNITS);
            end
            ST_BURST: if (tmr_done) begin
                nxt       = ST_GAP;
                tmr_load  = 1'b1;
                tmr_units = UNITS_W'(GAP_UNITS);
            end
            ST_GAP: if (tmr_done) nxt = (rounds_q == CW'(1)) ? ST_EVAL : ST_REQ_CHK;
            ST_EVAL: begin
                nxt       = ST_IDLE;
                tally_clr = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Round bookkeeping and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rounds_q <= '0;
            poll_q   <= '0;
            much_q   <= 1'b0;
            busy_q   <= 1'b0;
            pass_q   <= 1'b0;
            under_q  <= 1'b0;
            over_q   <= 1'b0;
            flag_q   <= 1'b0;
            warn_q   <= 1'b0;
            hv_q     <= 1'b0;
            ready_q  <= 1'b0;
        end else begin
            pass_q  <= 1'b0;
            under_q <= 1'b0;
            over_q  <= 1'b0;
            if (state_q == ST_IDLE && go_i) begin
                rounds_q <= CW'(ROUNDS);
                hv_q     <= 1'b1;
            end
            if (state_q == ST_GAP && tmr_done) rounds_q <= rounds_q - 1'b1;
            if (state_q == ST_POLL) begin
                poll_q <= poll_q + 1'b1;
                much_q <= aligned_i;
            end else begin
                poll_q <= '0;
            end
            if (nxt == ST_CLAMP)     busy_q <= 1'b1;
            else if (nxt == ST_IDLE) busy_q <= 1'b0;
            if (state_q == ST_EVAL) begin
                if (under_cond || over_cond) begin
                    if (!flag_q) begin
                        under_q <= under_cond;
                        over_q  <= over_cond;
                        flag_q  <= 1'b1;
                        warn_q  <= 1'b1;
                        hv_q    <= 1'b0;
                    end
                end else if (!jet_active_i) begin
                    pass_q  <= 1'b1;
                    ready_q <= 1'b1;
                end
            end
        end
    end

    assign clamp_n_o     = (state_q != ST_CLAMP);
    assign ctrl_code_o   = (state_q == ST_BURST) ? {much_q, 1'b0} : rest_code_i;
    assign busy_o        = busy_q;
    assign pass_o        = pass_q;
    assign fault_under_o = under_q;
    assign fault_over_o  = over_q;
    assign phase_fault_o = flag_q;
    assign warn_o        = warn_q;
    assign hv_on_o       = hv_q;
    assign ready_o       = ready_q;

    // R5
    clamp_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clamp_n_o |-> busy_o);

    // R9
    burst_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST) |-> busy_o);

    // R12
    pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> !(fault_under_o || fault_over_o));

    // R10
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_under_o && fault_over_o));

    // R11
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_fault_o) |-> (fault_under_o || fault_over_o));

    // R11
    fault_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_under_o || fault_over_o) |-> (!hv_on_o && warn_o));

endmodule

// File: tb/test_phase_align_seq.sv
module test_phase_align_seq;

    localparam int ROUNDS = 16;
    localparam int UNIT   = 4;
    localparam int OW     = 4;
    localparam int CLAMP_CYC = 57 * UNIT;
    localparam int BURST_CYC = 2 * UNIT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go_i = 1'b0;
    logic          phase_req_i = 1'b0;
    logic          sync_i = 1'b0;
    logic          aligned_i = 1'b0;
    logic          jet_active_i = 1'b0;
    logic [1:0]    rest_code_i = 2'b01;
    logic          clamp_n_o, busy_o, pass_o, fault_under_o, fault_over_o;
    logic          phase_fault_o, warn_o, hv_on_o, ready_o;
    logic [1:0]    ctrl_code_o;
    logic [OW-1:0] offset_o;

    int checks = 0;
    int fails  = 0;
    int mode   = 0;      // 0 all low, 1 all high, 2 alternating (much first)
    int falls = 0, clamp_low = 0, code10 = 0, code00 = 0;
    int n_pass = 0, n_under = 0, n_over = 0, sync_bad = 0, busy_bad = 0;
    logic clamp_prev = 1'b1;
    logic sync_at_edge = 1'b0;

    always #10 clk = ~clk;

    phase_align_seq #(.ROUNDS(ROUNDS), .UNIT_CYC(UNIT), .OFFSET_W(OW)) i_phase_align_seq (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .phase_req_i(phase_req_i),
        .sync_i(sync_i), .aligned_i(aligned_i), .jet_active_i(jet_active_i),
        .rest_code_i(rest_code_i), .clamp_n_o(clamp_n_o), .ctrl_code_o(ctrl_code_o),
        .busy_o(busy_o), .pass_o(pass_o), .fault_under_o(fault_under_o),
        .fault_over_o(fault_over_o), .phase_fault_o(phase_fault_o), .warn_o(warn_o),
        .hv_on_o(hv_on_o), .ready_o(ready_o), .offset_o(offset_o)
    );

    initial begin
        forever begin
            repeat (20) @(posedge clk);
            #5 sync_i = ~sync_i;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            aligned_i = (mode == 1) || (mode == 2 && falls[0]);
        end
    end

    always @(posedge clk) sync_at_edge <= sync_i;

    always @(negedge clk) begin
        if (clamp_prev && !clamp_n_o) begin
            falls = falls + 1;
            if (!sync_at_edge) sync_bad = sync_bad + 1;
            if (!busy_o) busy_bad = busy_bad + 1;
        end
        clamp_prev = clamp_n_o;
        if (!clamp_n_o) clamp_low = clamp_low + 1;
        if (ctrl_code_o == 2'b10) code10 = code10 + 1;
        if (ctrl_code_o == 2'b00) code00 = code00 + 1;
        if (pass_o) n_pass = n_pass + 1;
        if (fault_under_o) n_under = n_under + 1;
        if (fault_over_o) n_over = n_over + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        falls = 0; clamp_low = 0; code10 = 0; code00 = 0;
        n_pass = 0; n_under = 0; n_over = 0; sync_bad = 0; busy_bad = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_go();
        @(negedge clk);
        go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
    endtask

    task automatic wait_run_end();
        int t = 0;
        while (!busy_o && t < 2000) begin @(negedge clk); t++; end
        t = 0;
        while (busy_o && t < 20000) begin @(negedge clk); t++; end
        chk(!busy_o, "R5 busy drops at run end", busy_o, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(clamp_n_o == 1'b1, "R1 clamp", clamp_n_o, 1);
        chk({busy_o, ready_o, phase_fault_o, warn_o, hv_on_o} == 5'b0, "R1 flags",
            {busy_o, ready_o, phase_fault_o, warn_o, hv_on_o}, 0);
        chk(offset_o == OW'(8), "R1 offset", offset_o, 8);
        chk(ctrl_code_o == rest_code_i, "R1 rest code", ctrl_code_o, rest_code_i);
    endtask

    task automatic t_under();
        clear_mon(); mode = 1; phase_req_i = 1'b1; jet_active_i = 1'b0;
        pulse_go();
        chk(hv_on_o == 1'b1, "R13 hv on after go", hv_on_o, 1);
        wait_run_end();
        chk(falls == ROUNDS, "R2 round count", falls, ROUNDS);
        chk(sync_bad == 0, "R3 clamp on sync rise", sync_bad, 0);
        chk(busy_bad == 0, "R5 busy with clamp", busy_bad, 0);
        chk(clamp_low == ROUNDS * CLAMP_CYC, "R4 clamp width", clamp_low, ROUNDS * CLAMP_CYC);
        chk(code10 == ROUNDS * BURST_CYC, "R9 much burst", code10, ROUNDS * BURST_CYC);
        chk(n_under == 1 && n_over == 0 && n_pass == 0, "R10 under fault", n_under, 1);
        chk(phase_fault_o && warn_o && !hv_on_o, "R11 fault side effects",
            {phase_fault_o, warn_o, hv_on_o}, 3'b110);
        chk(offset_o == OW'(1), "R7 offset floor", offset_o, 1);
        chk(ctrl_code_o == rest_code_i, "R9 rest restored", ctrl_code_o, rest_code_i);
    endtask

    task automatic t_latched();
        clear_mon(); mode = 1;
        pulse_go();
        wait_run_end();
        chk(n_under == 0 && n_over == 0, "R11 no repeat fault", n_under + n_over, 0);
        chk(hv_on_o == 1'b1, "R11 hv untouched", hv_on_o, 1);
        chk(n_pass == 0 && !ready_o, "R12 no pass on fault", n_pass, 0);
    endtask

    task automatic t_over();
        do_reset();
        clear_mon(); mode = 0;
        pulse_go();
        wait_run_end();
        chk(n_over == 1 && n_under == 0, "R10 over fault", n_over, 1);
        chk(offset_o == OW'(15), "R7 offset ceiling", offset_o, 15);
        chk(code10 == 0, "R6 no much round", code10, 0);
        chk(code00 == ROUNDS * BURST_CYC, "R9 little burst", code00, ROUNDS * BURST_CYC);
        chk(phase_fault_o && !hv_on_o, "R11 over flags", phase_fault_o, 1);
    endtask

    task automatic t_pass();
        do_reset();
        clear_mon(); mode = 2; jet_active_i = 1'b0;
        pulse_go();
        wait_run_end();
        chk(n_pass == 1 && n_under == 0 && n_over == 0, "R12 pass pulse", n_pass, 1);
        chk(ready_o == 1'b1, "R12 ready set", ready_o, 1);
        chk(offset_o == OW'(8), "R7 mixed offset", offset_o, 8);
        chk(code10 == 8 * BURST_CYC, "R6 mixed grading", code10, 8 * BURST_CYC);
        clear_mon(); jet_active_i = 1'b1;
        pulse_go();
        wait_run_end();
        chk(n_pass == 0, "R12 pass suppressed", n_pass, 0);
        chk(n_under == 0 && n_over == 0, "R10 counts restart", n_under + n_over, 0);
        jet_active_i = 1'b0;
    endtask

    task automatic t_abort();
        int t;
        do_reset();
        clear_mon(); mode = 1; phase_req_i = 1'b0;
        pulse_go();
        repeat (300) @(negedge clk);
        chk(falls == 0 && !busy_o, "R2 abort at round start", falls, 0);
        phase_req_i = 1'b1;
        clear_mon();
        pulse_go();
        t = 0;
        while (falls == 0 && t < 2000) begin @(negedge clk); t++; end
        repeat (CLAMP_CYC + 20) @(negedge clk);
        phase_req_i = 1'b0;
        t = 0;
        while (busy_o && t < 2000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        chk(!busy_o, "R8 abort ends run", busy_o, 0);
        chk(offset_o == OW'(7), "R8 graded before abort", offset_o, 7);
        chk(code10 == 0, "R8 no burst after abort", code10, 0);
        chk(n_pass + n_under + n_over == 0, "R8 no outcome", n_pass + n_under + n_over, 0);
        chk(falls == 1 && clamp_n_o, "R8 single round", falls, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_under();
        t_latched();
        t_over();
        t_pass();
        t_abort();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule